// File: doc/BRIEF.md
# Conditional Skip Evaluation Unit

This unit sits beside an instruction sequencer and resolves the eight conditional-test instructions of a 16-bit processor. Each time the sequencer issues an instruction it presents the 5-bit opcode field, the two operand values (b is the destination-side operand, a the source-side operand) and the stack pointer as it stood before that instruction's operand fetch. When the opcode is a conditional test, the unit compares the operands, reports the cycle cost of the test and, when the test fails, arms a skip flag for the next instruction.

The next instruction the sequencer issues while the flag is armed is consumed by the skip. It has still been decoded and its operands fetched, but the unit tells the sequencer to drop its effects. The unit also returns the stack-pointer value to write back, which undoes any push or pop made by that instruction's operand fetch. Only one instruction is skipped per armed flag. A conditional that lands in the skipped slot is itself discarded and is not evaluated.

The control is a two-state machine. ST_IDLE means no skip is pending and ST_ARMED means a skip is pending. The transitions are T_ARM (ST_IDLE to ST_ARMED on a failing test), T_HOLD (stay in ST_IDLE), T_WAIT (stay in ST_ARMED on a cycle with no instruction) and T_CONSUME (ST_ARMED to ST_IDLE when the next instruction is issued).

Top module: `skip_eval_unit`

## Requirements
- R1: After reset the unit is in ST_IDLE: skip_o, done_o and discard_o are 0, and cost_o and sp_restore_o are zero.
- R2: Only opcode values 0x10 to 0x17 are conditional tests. In ST_IDLE any other opcode produces no done_o pulse and leaves skip_o at 0.
- R3: Opcode 0x10 fails (arms a skip) when (b AND a) is zero. Opcode 0x11 fails when (b AND a) is nonzero.
- R4: Opcode 0x12 fails when b differs from a. Opcode 0x13 fails when b equals a.
- R5: Opcode 0x14 fails unless b > a as unsigned values. Opcode 0x16 fails unless b < a as unsigned values.
- R6: Opcode 0x15 fails unless b > a as signed 16-bit values. Opcode 0x17 fails unless b < a as signed 16-bit values.
- R7: One cycle after a conditional is issued in ST_IDLE, done_o pulses for one cycle with cost_o = 2 when the test passes, or cost_o = 3 when it fails and a skip is armed.
- R8: skip_o is 1 from the cycle after a failing test until the next instruction is issued. Idle cycles keep it at 1, and it returns to 0 in the cycle after that next instruction.
- R9: One cycle after an instruction is issued while skip_o is 1, discard_o pulses for one cycle and sp_restore_o equals the sp_i value presented with that instruction. sp_restore_o is zero at all other times.
- R10: A conditional issued while skip_o is 1 is discarded as in R9. It produces no done_o and arms no new skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | An instruction is issued this cycle |
| opcode_i | input | 5 | Basic opcode field of the issued instruction |
| b_i | input | 16 | Operand b value |
| a_i | input | 16 | Operand a value |
| sp_i | input | 16 | Stack pointer before this instruction's operand fetch |
| skip_o | output | 1 | A skip is pending for the next instruction |
| done_o | output | 1 | Conditional evaluated, cost_o valid |
| cost_o | output | 2 | Cycle cost of the evaluated conditional |
| discard_o | output | 1 | The previous instruction was skipped; drop its effects |
| sp_restore_o | output | 16 | Stack pointer value to restore, valid with discard_o |

## Verification
Every result of this unit is registered. done_o, cost_o, discard_o and sp_restore_o all belong to the instruction issued one clock edge earlier, and skip_o changes on that same edge. The bench drives each instruction after a falling edge, waits for the next rising edge, and samples all outputs one nanosecond later. It then compares them with a reference model that updates its expected skip state at the same boundary. Idle gaps of random length are placed between instructions so that the hold of skip_o across cycles with no instruction is sampled on each of those cycles.

// File: rtl/skip_pkg.sv
package skip_pkg;

    localparam int OP_W = 5;

    // Conditional opcodes share the high bits 2'b10; the low three bits select the test
    localparam logic [1:0] COND_HI = 2'b10;

    typedef enum logic [2:0] {
        TST_BITS_ANY  = 3'd0,
        TST_BITS_NONE = 3'd1,
        TST_EQUAL     = 3'd2,
        TST_UNEQUAL   = 3'd3,
        TST_UGREATER  = 3'd4,
        TST_SGREATER  = 3'd5,
        TST_ULESS     = 3'd6,
        TST_SLESS     = 3'd7
    } test_sel_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } skip_state_e;

endpackage

// File: rtl/skip_cond_eval.sv
module skip_cond_eval
    import skip_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [OP_W-1:0]   opcode_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] a_i,
    output logic              is_cond_o,
    output logic              skip_req_o
);

    localparam int NUM_TESTS = 8;

    logic [NUM_TESTS-1:0] pass_vec;
    logic                 any_common;
    test_sel_e            sel;

    assign any_common = |(b_i & a_i);
    assign sel        = test_sel_e'(opcode_i[2:0]);
    assign is_cond_o  = (opcode_i[OP_W-1:OP_W-2] == COND_HI);

    // Evaluate every test in parallel; the opcode only steers the final mux
    generate
        for (genvar t = 0; t < NUM_TESTS; t++) begin : g_test
            always_comb begin
                unique case (test_sel_e'(t))
                    TST_BITS_ANY:  pass_vec[t] = any_common;
                    TST_BITS_NONE: pass_vec[t] = !any_common;
                    TST_EQUAL:     pass_vec[t] = (b_i == a_i);
                    TST_UNEQUAL:   pass_vec[t] = (b_i != a_i);
                    TST_UGREATER:  pass_vec[t] = (b_i > a_i);
                    TST_SGREATER:  pass_vec[t] = ($signed(b_i) > $signed(a_i));
                    TST_ULESS:     pass_vec[t] = (b_i < a_i);
                    TST_SLESS:     pass_vec[t] = ($signed(b_i) < $signed(a_i));
                    default:       pass_vec[t] = 1'b1;
                endcase
            end
        end
    endgenerate

    // A failed test requests a skip of the following instruction
    assign skip_req_o = is_cond_o && !pass_vec[sel];

endmodule

// File: rtl/skip_cost_calc.sv
module skip_cost_calc #(
    parameter int BASE_COST    = 2,
    parameter int SKIP_PENALTY = 1,
    parameter int COST_W       = 2
) (
    input  logic              taken_i,
    output logic [COST_W-1:0] cost_o
);

    localparam logic [COST_W-1:0] BASE_V = COST_W'(BASE_COST);
    localparam logic [COST_W-1:0] PEN_V  = COST_W'(SKIP_PENALTY);

    assign cost_o = taken_i ? (BASE_V + PEN_V) : BASE_V;

endmodule

// File: rtl/skip_seq_fsm.sv
module skip_seq_fsm
    import skip_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int BASE_COST    = 2,
    parameter int SKIP_PENALTY = 1,
    parameter int COST_W       = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              instr_valid_i,
    input  logic              is_cond_i,
    input  logic              skip_req_i,
    input  logic [COST_W-1:0] cost_i,
    input  logic [DATA_W-1:0] sp_i,
    output logic              skip_o,
    output logic              done_o,
    output logic [COST_W-1:0] cost_o,
    output logic              discard_o,
    output logic [DATA_W-1:0] sp_restore_o
);

    skip_state_e state_q, state_d;

    logic              done_d;
    logic [COST_W-1:0] cost_d;
    logic              discard_d;
    logic [DATA_W-1:0] sp_d;

    // Next-state logic: T_ARM, T_HOLD, T_WAIT, T_CONSUME
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_valid_i && skip_req_i) begin
                    state_d = ST_ARMED;          // T_ARM
                end else begin
                    state_d = ST_IDLE;           // T_HOLD
                end
            end
            ST_ARMED: begin
                if (instr_valid_i) begin
                    state_d = ST_IDLE;           // T_CONSUME
                end else begin
                    state_d = ST_ARMED;          // T_WAIT
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Next-output logic
    always_comb begin
        done_d    = 1'b0;
        cost_d    = '0;
        discard_d = 1'b0;
        sp_d      = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_valid_i && is_cond_i) begin
                    done_d = 1'b1;
                    cost_d = cost_i;
                end
            end
            ST_ARMED: begin
                if (instr_valid_i) begin
                    discard_d = 1'b1;
                    sp_d      = sp_i;
                end
            end
            default: ;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            done_o       <= 1'b0;
            cost_o       <= '0;
            discard_o    <= 1'b0;
            sp_restore_o <= '0;
        end else begin
            done_o       <= done_d;
            cost_o       <= cost_d;
            discard_o    <= discard_d;
            sp_restore_o <= sp_d;
        end
    end

    assign skip_o = (state_q == ST_ARMED);

    AST_SKIP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (skip_o && !instr_valid_i) |=> skip_o); // R8

    AST_SKIP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (skip_o && instr_valid_i) |=> !skip_o); // R8

    AST_DISCARD_AFTER_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        discard_o |-> $past(skip_o)); // R9

    AST_NO_EVAL_WHEN_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && discard_o)); // R10

    AST_ARM_COMES_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(skip_o) |-> done_o); // R7

    AST_COST_MATCHES_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ((cost_o == COST_W'(BASE_COST + SKIP_PENALTY)) == skip_o)); // R7

endmodule

// File: rtl/skip_eval_unit.sv
module skip_eval_unit
    import skip_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int BASE_COST    = 2,
    parameter int SKIP_PENALTY = 1,
    localparam int COST_W      = $clog2(BASE_COST + SKIP_PENALTY + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              instr_valid_i,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] sp_i,
    output logic              skip_o,
    output logic              done_o,
    output logic [COST_W-1:0] cost_o,
    output logic              discard_o,
    output logic [DATA_W-1:0] sp_restore_o
);

    logic              is_cond;
    logic              skip_req;
    logic [COST_W-1:0] cost_now;

    skip_cond_eval #(
        .DATA_W (DATA_W)
    ) u_eval (
        .opcode_i   (opcode_i),
        .b_i        (b_i),
        .a_i        (a_i),
        .is_cond_o  (is_cond),
        .skip_req_o (skip_req)
    );

    skip_cost_calc #(
        .BASE_COST    (BASE_COST),
        .SKIP_PENALTY (SKIP_PENALTY),
        .COST_W       (COST_W)
    ) u_cost (
        .taken_i (skip_req),
        .cost_o  (cost_now)
    );

    skip_seq_fsm #(
        .DATA_W       (DATA_W),
        .BASE_COST    (BASE_COST),
        .SKIP_PENALTY (SKIP_PENALTY),
        .COST_W       (COST_W)
    ) u_fsm (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .instr_valid_i (instr_valid_i),
        .is_cond_i     (is_cond),
        .skip_req_i    (skip_req),
        .cost_i        (cost_now),
        .sp_i          (sp_i),
        .skip_o        (skip_o),
        .done_o        (done_o),
        .cost_o        (cost_o),
        .discard_o     (discard_o),
        .sp_restore_o  (sp_restore_o)
    );

    AST_RESTORE_ONLY_ON_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !discard_o |-> (sp_restore_o == '0)); // R9

    AST_NONCOND_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_valid_i && !skip_o && (opcode_i[OP_W-1:OP_W-2] != 2'b10)) |=> !done_o); // R2

endmodule

// File: tb/tb_skip_eval_unit.sv
`timescale 1ns/1ps
module tb_skip_eval_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        vld;
    logic [4:0]  op;
    logic [15:0] b, a, sp;
    logic        skip_o, done_o, discard_o;
    logic [1:0]  cost_o;
    logic [15:0] sp_restore_o;

    int checks = 0;
    int fails  = 0;
    bit exp_armed = 1'b0;
    bit finished  = 1'b0;

    always #5 clk = ~clk;

    skip_eval_unit dut (
        .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(vld), .opcode_i(op),
        .b_i(b), .a_i(a), .sp_i(sp), .skip_o(skip_o), .done_o(done_o),
        .cost_o(cost_o), .discard_o(discard_o), .sp_restore_o(sp_restore_o)
    );

    function automatic bit is_cond(input logic [4:0] o);
        return (o >= 5'h10) && (o <= 5'h17);
    endfunction

    // Reference: returns 1 when the test fails, i.e. a skip must be armed
    function automatic bit ref_skip(input logic [4:0] o, input logic [15:0] bb, input logic [15:0] aa);
        case (o)
            5'h10: return (bb & aa) == 16'h0;
            5'h11: return (bb & aa) != 16'h0;
            5'h12: return bb != aa;
            5'h13: return bb == aa;
            5'h14: return !(bb > aa);
            5'h15: return !($signed(bb) > $signed(aa));
            5'h16: return !(bb < aa);
            5'h17: return !($signed(bb) < $signed(aa));
            default: return 1'b0;
        endcase
    endfunction

    function automatic string op_tag(input logic [4:0] o);
        case (o)
            5'h10, 5'h11: return "R3";
            5'h12, 5'h13: return "R4";
            5'h14, 5'h16: return "R5";
            5'h15, 5'h17: return "R6";
            default:      return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] o, input logic [15:0] bb, input logic [15:0] aa, input logic [15:0] s);
        bit    e_done, e_disc, next_armed;
        logic [1:0]  e_cost;
        logic [15:0] e_sp;
        string tag;
        e_done = 0; e_disc = 0; e_cost = 2'd0; e_sp = 16'h0;
        tag = op_tag(o);
        if (exp_armed) begin
            e_disc = 1; e_sp = s; next_armed = 0;
            tag = is_cond(o) ? "R10" : "R9";
        end else if (is_cond(o)) begin
            next_armed = ref_skip(o, bb, aa);
            e_done = 1; e_cost = next_armed ? 2'd3 : 2'd2;
        end else begin
            next_armed = 0;
        end
        @(negedge clk);
        vld = 1'b1; op = o; b = bb; a = aa; sp = s;
        @(posedge clk);
        #1;
        vld = 1'b0;
        exp_armed = next_armed;
        chk(tag,  "skip_o",       skip_o,       exp_armed);
        chk("R7", "done_o",       done_o,       e_done);
        chk("R7", "cost_o",       cost_o,       e_cost);
        chk("R9", "discard_o",    discard_o,    e_disc);
        chk("R9", "sp_restore_o", sp_restore_o, e_sp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            chk("R8", "skip_o idle", skip_o, exp_armed);
            chk("R9", "discard_o idle", discard_o, 1'b0);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; vld = 1'b0; op = '0; b = '0; a = '0; sp = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "skip_o", skip_o, 0);
        chk("R1", "done_o", done_o, 0);
        chk("R1", "discard_o", discard_o, 0);
        chk("R1", "cost_o", cost_o, 0);
        chk("R1", "sp_restore_o", sp_restore_o, 0);

        // R2: non-conditional opcodes are not evaluated
        issue(5'h01, 16'h0, 16'h1, 16'hFFF0);
        issue(5'h18, 16'h5, 16'h5, 16'hFFF0);
        issue(5'h0F, 16'h1, 16'h2, 16'hFFF0);

        // R3: bit tests
        issue(5'h10, 16'h00F0, 16'h0F00, 16'h1000); // fails -> arm
        issue(5'h01, 16'h0, 16'h0, 16'h0FFF);       // discarded, R9
        issue(5'h10, 16'h00F0, 16'h0010, 16'h1000); // passes
        issue(5'h11, 16'h8000, 16'h8000, 16'h2000); // fails
        idle(4);                                    // R8 hold
        issue(5'h02, 16'h0, 16'h0, 16'hABCD);       // discarded, R9

        // R4: equality
        issue(5'h12, 16'h1234, 16'h1234, 16'h0);
        issue(5'h13, 16'h1234, 16'h1234, 16'h0);
        // R10: conditional in the skipped slot is discarded, not evaluated
        issue(5'h12, 16'h1, 16'h2, 16'h7777);
        issue(5'h12, 16'h1, 16'h2, 16'h0);          // fails -> arm
        issue(5'h13, 16'h1, 16'h2, 16'h5555);       // discarded, R10

        // R5/R6: unsigned and signed corners
        issue(5'h14, 16'h8000, 16'h7FFF, 16'h0);    // unsigned greater: pass
        issue(5'h15, 16'h8000, 16'h7FFF, 16'h0);    // signed: -32768 > 32767 false -> arm
        issue(5'h00, 16'h0, 16'h0, 16'h3333);
        issue(5'h16, 16'hFFFF, 16'hFFFF, 16'h0);    // equal, not less -> arm
        issue(5'h00, 16'h0, 16'h0, 16'h4444);
        issue(5'h17, 16'hFFFF, 16'h0000, 16'h0);    // -1 < 0 pass
        issue(5'h14, 16'h0005, 16'h0005, 16'h0);    // equal, not greater -> arm
        issue(5'h17, 16'h0000, 16'hFFFF, 16'h0101); // discarded, R10

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            logic [4:0]  ro;
            logic [15:0] rb, ra, rs;
            int pick;
            pick = $urandom_range(0, 9);
            ro = (pick < 8) ? 5'(5'h10 + $urandom_range(0, 7)) : 5'($urandom_range(0, 31));
            ra = 16'($urandom);
            case ($urandom_range(0, 4))
                0: rb = ra;
                1: rb = ra ^ (16'h1 << $urandom_range(0, 15));
                2: rb = (($urandom_range(0, 1) != 0) ? 16'h8000 : 16'h7FFF);
                default: rb = 16'($urandom);
            endcase
            rs = 16'($urandom);
            issue(ro, rb, ra, rs);
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end

        finish_run();
    end

endmodule